// File: doc/BRIEF.md
# Interval Clock with Time-of-Year Counter

This block gives a small processor a periodic timebase and a running wall-clock value. A prescaler divides the system clock down to a 100 Hz tick. On each tick the block can raise a clock interrupt, and it advances a 32-bit time-of-year count whose unit is 10 ms. A loaded time conventionally carries an offset of 0x10000000, which software adds before writing. The count stays frozen after power-up, while a battery-low flag is set. Software clears that flag by writing a nonzero time.

Software sees two registers on a simple register bus. Address 0 is the clock status register, whose only implemented bit is the interrupt enable at bit 6. Address 1 is the time-of-year register. Reads are combinational and have no side effects. Writes take effect at the next clock edge. The block has two resets. A power-up reset clears everything and sets the battery-low flag. A soft reset clears only the enable and the pending interrupt and restarts the prescaler, so the stored time survives a soft reset.

Top module: `ivl_tod_clock`

## Requirements
- R1: While `por_n` is low, the time-of-year register is cleared to 0 and the battery-low flag is set. The status register reads 0 and `irq_o` is low.
- R2: `tick_o` is a one-cycle pulse that repeats every DIV = CLK_HZ / TICK_HZ clock cycles.
- R3: While the battery-low flag is set, ticks leave the time-of-year register unchanged. Writing the value 0 to address 1 loads 0 and leaves the flag set.
- R4: Writing a nonzero value to address 1 loads it at the next edge and clears the battery-low flag. After that, each tick adds one to the register.
- R5: The time-of-year register wraps from 0xFFFFFFFF to 0, and it keeps counting after reaching 0.
- R6: A tick while the enable (status bit 6) is set raises `irq_o` at the next edge. The request stays high until `irq_ack` is pulsed or the enable is written to 0.
- R7: A tick while the enable is clear raises no interrupt.
- R8: Writing address 0 with bit 6 clear withdraws a pending interrupt. Only bit 6 is stored and read back; every other status bit reads 0.
- R9: A low `rst_n` clears the enable and the pending interrupt. It keeps the time-of-year value and the battery-low state, and it restarts the prescaler so that the next tick comes DIV-1 cycles after release.
- R10: A write to address 1 in the same cycle as a tick loads the written value with no increment.
- R11: An `irq_ack` in the same cycle as a tick with the enable set leaves `irq_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-up reset, active low, synchronous |
| rst_n | input | 1 | Soft reset, active low, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects time-of-year |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Pending clock interrupt |
| tick_o | output | 1 | 100 Hz tick pulse |

## Verification
Two pairs of events can fall in the same clock cycle. A software load of the time-of-year register can coincide with a tick, and an interrupt acknowledge can coincide with a new tick. The bench watches `tick_o` at the falling edge and drives the write or the acknowledge on that same half-cycle, so both land on the tick's edge. It then judges the result against the rules: the loaded value appears with no increment, and the interrupt stays pending because the new tick outranks the acknowledge.

// File: rtl/tod_pkg.sv
package tod_pkg;
    localparam int TOD_W  = 32;
    localparam int IE_BIT = 6;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_TOD    = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int DIV = 500000
) (
    input  logic clk,
    input  logic clr,
    output logic tick
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == LAST);
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         batt_low
);
    typedef struct packed {
        logic         low;
        logic [W-1:0] val;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            // a load outranks a coinciding tick
            st_d.val = load_val;
            if (load_val != '0) begin
                st_d.low = 1'b0;
            end
        end else if (tick && !st_q.low) begin
            st_d.val = st_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q.val <= '0;
            st_q.low <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.val;
    assign batt_low = st_q.low;
endmodule

// File: rtl/tod_irq_ctl.sv
module tod_irq_ctl (
    input  logic clk,
    input  logic clr,
    input  logic tick,
    input  logic csr_wr,
    input  logic ie_wval,
    input  logic ack,
    output logic ie,
    output logic irq
);
    typedef struct packed {
        logic ie;
        logic irq;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic       withdraw;
    logic       raise;

    always_comb begin
        withdraw = csr_wr && !ie_wval;
        raise    = tick && st_q.ie && !withdraw;
        st_d     = st_q;
        if (csr_wr) begin
            st_d.ie = ie_wval;
        end
        // a new tick outranks an acknowledge; disabling outranks both
        st_d.irq = raise || (st_q.irq && !ack && !withdraw);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ie  = st_q.ie;
    assign irq = st_q.irq;
endmodule

// File: rtl/ivl_tod_clock.sv
module ivl_tod_clock
    import tod_pkg::*;
#(
    parameter int CLK_HZ  = 50000000,
    parameter int TICK_HZ = 100
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [TOD_W-1:0] reg_wdata,
    output logic [TOD_W-1:0] reg_rdata,
    input  logic             irq_ack,
    output logic             irq_o,
    output logic             tick_o
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic             soft_clr;
    logic             tick;
    logic             tod_load;
    logic             csr_write;
    logic [TOD_W-1:0] tod_val;
    logic             batt_low;
    logic             ie;
    logic             irq;
    reg_sel_e         sel;

    assign sel       = reg_sel_e'(reg_addr);
    assign soft_clr  = !por_n || !rst_n;
    assign tod_load  = reg_wr && (sel == SEL_TOD);
    assign csr_write = reg_wr && (sel == SEL_STATUS);

    tod_prescaler #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .clr  (soft_clr),
        .tick (tick)
    );

    tod_counter #(.W(TOD_W)) u_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .tick     (tick),
        .load     (tod_load),
        .load_val (reg_wdata),
        .count    (tod_val),
        .batt_low (batt_low)
    );

    tod_irq_ctl u_irq (
        .clk     (clk),
        .clr     (soft_clr),
        .tick    (tick),
        .csr_wr  (csr_write),
        .ie_wval (reg_wdata[IE_BIT]),
        .ack     (irq_ack),
        .ie      (ie),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel == SEL_TOD) begin
            reg_rdata = tod_val;
        end else begin
            reg_rdata[IE_BIT] = ie;
        end
    end

    assign irq_o  = irq;
    assign tick_o = tick;
endmodule

// File: rtl/ivl_tod_clock_chk.sv
module ivl_tod_clock_chk
    import tod_pkg::*;
(
    input logic             clk,
    input logic             por_n,
    input logic             rst_n,
    input logic             tick,
    input logic             reg_wr,
    input logic             reg_addr,
    input logic [TOD_W-1:0] reg_wdata,
    input logic             irq_ack,
    input logic             irq,
    input logic             ie,
    input logic             batt_low,
    input logic [TOD_W-1:0] tod
);
    logic tod_wr;
    logic ie_off_wr;
    logic soft_seen_q;
    logic por_seen_q;

    assign tod_wr    = reg_wr && reg_addr;
    assign ie_off_wr = reg_wr && !reg_addr && !reg_wdata[IE_BIT];

    assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        tick |=> !tick);

    assert_frozen_R3: assert property (@(posedge clk) disable iff (!por_n)
        (batt_low && !tod_wr) |=> $stable(tod));

    assert_count_R4: assert property (@(posedge clk) disable iff (!por_n)
        (tick && !batt_low && !tod_wr) |=> (tod == $past(tod) + 1'b1));

    assert_load_R10: assert property (@(posedge clk) disable iff (!por_n)
        tod_wr |=> (tod == $past(reg_wdata)));

    assert_irq_raise_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (tick && ie && !ie_off_wr) |=> irq);

    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (irq && !irq_ack && !ie_off_wr) |=> irq);

    assert_no_irq_R7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (!irq && !(tick && ie)) |=> !irq);

    assert_withdraw_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        ie_off_wr |=> (!irq && !ie));

    always_ff @(posedge clk) begin
        soft_seen_q <= !rst_n;
        por_seen_q  <= !por_n;
    end

    always @(negedge clk) begin
        if (soft_seen_q) begin
            assert_soft_clear_R9: assert (!irq && !ie);
        end
        if (por_seen_q) begin
            assert_powerup_R1: assert (batt_low && tod == '0 && !irq);
        end
    end
endmodule

bind ivl_tod_clock ivl_tod_clock_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .tick      (tick),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_ack   (irq_ack),
    .irq       (irq),
    .ie        (ie),
    .batt_low  (batt_low),
    .tod       (tod_val)
);

// File: tb/ivl_tod_clock_tb.sv
module ivl_tod_clock_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1000;
    localparam int TICK_HZ    = 100;
    localparam int DIV        = CLK_HZ / TICK_HZ;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_o;
    logic        tick_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ivl_tod_clock #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u_dut (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_ack   (irq_ack),
        .irq_o     (irq_o),
        .tick_o    (tick_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // drive at a falling edge; takes effect at the next rising edge
    task automatic wr(input logic a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_tick;
        for (int i = 0; i < 4 * DIV; i++) begin
            if (tick_o) return;
            @(negedge clk);
        end
    endtask

    // wait for a tick and let it be applied
    task automatic pass_tick;
        wait_tick();
        @(negedge clk);
    endtask

    task automatic t_powerup;
        logic [31:0] v;
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        rd(1'b1, v); check("R1 tod", v, 32'h0);
        rd(1'b0, v); check("R1 status", v, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        por_n = 1'b1;
    endtask

    task automatic t_period;
        int n;
        wait_tick();
        @(negedge clk);
        check("R2 width", {31'b0, tick_o}, 32'h0);
        n = 1;
        while (!tick_o && n < 4 * DIV) begin
            @(negedge clk);
            n++;
        end
        check("R2 period", n, DIV);
    endtask

    task automatic t_frozen;
        logic [31:0] v;
        repeat (3) pass_tick();
        rd(1'b1, v); check("R3 frozen", v, 32'h0);
        wr(1'b1, 32'h0);
        repeat (2) pass_tick();
        rd(1'b1, v); check("R3 zero write keeps flag", v, 32'h0);
    endtask

    task automatic t_load;
        logic [31:0] v;
        wr(1'b1, 32'h1000_0005);
        rd(1'b1, v); check("R4 load", v, 32'h1000_0005);
        pass_tick();
        rd(1'b1, v); check("R4 first count", v, 32'h1000_0006);
        pass_tick();
        rd(1'b1, v); check("R4 second count", v, 32'h1000_0007);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(1'b1, 32'hFFFF_FFFE);
        pass_tick();
        rd(1'b1, v); check("R5 top", v, 32'hFFFF_FFFF);
        pass_tick();
        rd(1'b1, v); check("R5 wrap", v, 32'h0);
        pass_tick();
        rd(1'b1, v); check("R5 after wrap", v, 32'h1);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        pass_tick();
        check("R7 no irq when disabled", {31'b0, irq_o}, 32'h0);
        wr(1'b0, 32'h40);
        rd(1'b0, v); check("R8 status readback", v, 32'h40);
        pass_tick();
        check("R6 raise", {31'b0, irq_o}, 32'h1);
        repeat (3) @(negedge clk);
        check("R6 held", {31'b0, irq_o}, 32'h1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check("R6 ack clears", {31'b0, irq_o}, 32'h0);
        pass_tick();
        check("R6 raise again", {31'b0, irq_o}, 32'h1);
        wr(1'b0, 32'hFFFF_FFBF);
        check("R8 withdraw", {31'b0, irq_o}, 32'h0);
        rd(1'b0, v); check("R8 other bits ignored", v, 32'h0);
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); check("R8 only enable stored", v, 32'h40);
    endtask

    task automatic t_ack_tick;
        wait_tick();
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check("R11 tick beats ack", {31'b0, irq_o}, 32'h1);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        check("R11 later ack", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_load_tick;
        logic [31:0] v;
        wait_tick();
        wr(1'b1, 32'h1234_5678);
        rd(1'b1, v); check("R10 load wins", v, 32'h1234_5678);
        pass_tick();
        rd(1'b1, v); check("R10 count after", v, 32'h1234_5679);
    endtask

    task automatic t_soft_reset;
        logic [31:0] v;
        logic [31:0] keep;
        int n;
        pass_tick();
        check("R9 irq before reset", {31'b0, irq_o}, 32'h1);
        rd(1'b1, keep);
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        check("R9 irq cleared", {31'b0, irq_o}, 32'h0);
        rd(1'b0, v); check("R9 enable cleared", v, 32'h0);
        rd(1'b1, v); check("R9 tod kept", v, keep);
        n = 0;
        while (!tick_o && n < 4 * DIV) begin
            @(negedge clk);
            n++;
        end
        check("R9 prescaler restart", n, DIV - 1);
        @(negedge clk);
        rd(1'b1, v); check("R9 still counting", v, keep + 32'd1);
        check("R9 no irq after reset", {31'b0, irq_o}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_powerup();
        t_period();
        t_frozen();
        t_load();
        t_wrap();
        t_irq();
        t_ack_tick();
        t_load_tick();
        t_soft_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule